// File: doc/BRIEF.md
# Pipeline Hazard Interlock Unit

This unit is the hazard and operand-bypass control for an in-order integer pipeline with five stages: fetch, decode, execute, memory and write-back. In every cycle it looks at a short descriptor held in each pipeline register. A descriptor has a valid bit, an instruction class, and source and destination register numbers. When it finds a hazard, it holds fetch and decode in place and tells the execute stage to take an empty slot (a bubble). The later stages keep moving.

The register file has one read-only port and one read/write port. An arithmetic instruction in decode needs two reads. If the instruction in write-back is writing in that same cycle, the decode instruction has to wait one cycle.

A read-after-write dependency is normally handled by bypassing. The value comes from the execute/memory register or the memory/write-back register, whichever holds the newest copy. A load followed at once by a consumer of its result cannot be bypassed, so the consumer stalls once. The selects for the instruction that will enter execute are worked out again every cycle, including stall cycles, from what the pipeline registers hold at that moment. They are registered so they are valid while that instruction is in execute.

A register written by the write-back stage can be read in decode in the same cycle, because the register file writes before it reads. Dependencies on the write-back stage therefore need no bypass.

Top module: `hzd_interlock`

## Requirements
- R1: While reset is active, both bypass selects read 00 (register file).
- R2: `front_stall` and `ex_bubble` are combinational and rise in the same cycle. They are high exactly when a structural or load-use hazard exists, and low otherwise.
- R3: A valid arithmetic instruction in decode (class 00) stalls while write-back holds a valid arithmetic (00) or load (01) instruction, whatever the destination register.
- R4: A valid decode instruction stalls when execute holds a valid load (class 01) whose destination is nonzero and equals a source that the decode instruction reads.
- R5: When a source of the decode instruction is nonzero and matches the destination of a valid arithmetic instruction in execute, and no stall occurs, the select for that operand reads 01 (execute/memory result) in the next cycle. This holds even when memory also matches. The select value 11 never appears.
- R6: When only a valid arithmetic or load instruction in memory matches, the select reads 10 (memory/write-back result) in the next cycle.
- R7: A source number of 0 never stalls and never selects a bypass.
- R8: Entries with the valid bit clear never cause a stall and never match for bypass. An invalid decode entry gives selects of 00.
- R9: Only arithmetic instructions read source B. For loads (01), stores (10) and branches (11), source B never stalls and its select reads 00. Stores and branches never act as bypass producers.
- R10: A stall cycle sets both selects to 00 in the next cycle, because execute receives a bubble. A structural hazard and a load-use hazard in the same cycle give a single one-cycle stall, after which the conditions are evaluated afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid | input | 1 | Decode entry valid |
| id_cls | input | 2 | Decode class: 00 arith, 01 load, 10 store, 11 branch |
| id_src_a | input | REG_AW | Decode source A register |
| id_src_b | input | REG_AW | Decode source B register (arith only) |
| ex_valid | input | 1 | Execute entry valid |
| ex_cls | input | 2 | Execute class |
| ex_dst | input | REG_AW | Execute destination register |
| mem_valid | input | 1 | Memory entry valid |
| mem_cls | input | 2 | Memory class |
| mem_dst | input | REG_AW | Memory destination register |
| wb_valid | input | 1 | Write-back entry valid |
| wb_cls | input | 2 | Write-back class |
| front_stall | output | 1 | Hold fetch and decode this cycle |
| ex_bubble | output | 1 | Load a bubble into execute this cycle |
| fwd_sel_a | output | 2 | Operand A source for the execute instruction |
| fwd_sel_b | output | 2 | Operand B source for the execute instruction |

## Verification
The bench starts with directed sequences, one for each case:
- a dual-read arithmetic instruction against a writing and a non-writing write-back entry, which separates the port conflict from register matching;
- a load-use pair followed by its resumption, which shows the stall, then the bubble selects, then the late bypass from memory/write-back;
- a register matching both execute and memory, which exposes the priority order;
- register 0, invalid producers and non-arithmetic consumers, which shows that each of them is ignored.

After that, randomised descriptors with register numbers limited to a few values make matches frequent. These mix hazards together, including structural and load-use hazards in the same cycle, against a behavioural reference that is checked every cycle.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    typedef enum logic [1:0] {
        CLS_ALU    = 2'b00,
        CLS_LOAD   = 2'b01,
        CLS_STORE  = 2'b10,
        CLS_BRANCH = 2'b11
    } op_class_e;

    typedef enum logic [1:0] {
        SRC_RF    = 2'b00,
        SRC_EXMEM = 2'b01,
        SRC_MEMWB = 2'b10
    } opnd_src_e;

    typedef struct packed {
        opnd_src_e sel_a;
        opnd_src_e sel_b;
    } fwd_state_t;

    // Classes that put a result into the register file in write-back
    function automatic logic cls_writes(input logic [1:0] cls);
        return (cls == CLS_ALU) || (cls == CLS_LOAD);
    endfunction

    // Only register-register operations need a second read
    function automatic logic cls_reads_b(input logic [1:0] cls);
        return cls == CLS_ALU;
    endfunction

endpackage

// File: rtl/hzd_port_check.sv
module hzd_port_check
    import hzd_pkg::*;
(
    input  logic       id_valid,
    input  logic [1:0] id_cls,
    input  logic       wb_valid,
    input  logic [1:0] wb_cls,
    output logic       conflict
);
    logic needs_two_reads;
    logic write_port_busy;

    always_comb begin
        needs_two_reads = id_valid && cls_reads_b(id_cls);
        write_port_busy = wb_valid && cls_writes(wb_cls);
        conflict        = needs_two_reads && write_port_busy;
    end
endmodule

// File: rtl/hzd_loaduse.sv
module hzd_loaduse
    import hzd_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              id_valid,
    input  logic [1:0]        id_cls,
    input  logic [REG_AW-1:0] id_src_a,
    input  logic [REG_AW-1:0] id_src_b,
    input  logic              ex_valid,
    input  logic [1:0]        ex_cls,
    input  logic [REG_AW-1:0] ex_dst,
    output logic              hit
);
    logic load_pending;
    logic match_a;
    logic match_b;

    always_comb begin
        load_pending = ex_valid && (ex_cls == CLS_LOAD) && (ex_dst != '0);
        match_a      = (id_src_a == ex_dst);
        match_b      = cls_reads_b(id_cls) && (id_src_b == ex_dst);
        hit          = id_valid && load_pending && (match_a || match_b);
    end
endmodule

// File: rtl/hzd_fwd_pick.sv
module hzd_fwd_pick
    import hzd_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              use_src,
    input  logic [REG_AW-1:0] src,
    input  logic              ex_valid,
    input  logic [1:0]        ex_cls,
    input  logic [REG_AW-1:0] ex_dst,
    input  logic              mem_valid,
    input  logic [1:0]        mem_cls,
    input  logic [REG_AW-1:0] mem_dst,
    output logic [1:0]        sel
);
    logic live;
    logic near_hit;
    logic far_hit;

    always_comb begin
        live     = use_src && (src != '0);
        // The execute entry moves into the execute/memory register next
        // cycle; only an arithmetic result already exists there.
        near_hit = live && ex_valid && (ex_cls == CLS_ALU) && (ex_dst == src);
        far_hit  = live && mem_valid && cls_writes(mem_cls) && (mem_dst == src);
        if (near_hit)     sel = SRC_EXMEM;
        else if (far_hit) sel = SRC_MEMWB;
        else              sel = SRC_RF;
    end
endmodule

// File: rtl/hzd_interlock.sv
module hzd_interlock
    import hzd_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              id_valid,
    input  logic [1:0]        id_cls,
    input  logic [REG_AW-1:0] id_src_a,
    input  logic [REG_AW-1:0] id_src_b,
    input  logic              ex_valid,
    input  logic [1:0]        ex_cls,
    input  logic [REG_AW-1:0] ex_dst,
    input  logic              mem_valid,
    input  logic [1:0]        mem_cls,
    input  logic [REG_AW-1:0] mem_dst,
    input  logic              wb_valid,
    input  logic [1:0]        wb_cls,
    output logic              front_stall,
    output logic              ex_bubble,
    output logic [1:0]        fwd_sel_a,
    output logic [1:0]        fwd_sel_b
);
    localparam int NSRC = 2;

    logic                          port_hit;
    logic                          lu_hit;
    logic                          stall;
    logic [NSRC-1:0]               src_used;
    logic [NSRC-1:0][REG_AW-1:0]   src_num;
    logic [NSRC-1:0][1:0]          pick;
    fwd_state_t                    st_d;
    fwd_state_t                    st_q;

    hzd_port_check u_port (
        .id_valid (id_valid),
        .id_cls   (id_cls),
        .wb_valid (wb_valid),
        .wb_cls   (wb_cls),
        .conflict (port_hit)
    );

    hzd_loaduse #(.REG_AW(REG_AW)) u_lu (
        .id_valid (id_valid),
        .id_cls   (id_cls),
        .id_src_a (id_src_a),
        .id_src_b (id_src_b),
        .ex_valid (ex_valid),
        .ex_cls   (ex_cls),
        .ex_dst   (ex_dst),
        .hit      (lu_hit)
    );

    always_comb begin
        src_num[0]  = id_src_a;
        src_num[1]  = id_src_b;
        src_used[0] = id_valid;
        src_used[1] = id_valid && cls_reads_b(id_cls);
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_pick
        hzd_fwd_pick #(.REG_AW(REG_AW)) u_pick (
            .use_src   (src_used[g]),
            .src       (src_num[g]),
            .ex_valid  (ex_valid),
            .ex_cls    (ex_cls),
            .ex_dst    (ex_dst),
            .mem_valid (mem_valid),
            .mem_cls   (mem_cls),
            .mem_dst   (mem_dst),
            .sel       (pick[g])
        );
    end

    // Both hazards collapse into one hold; re-evaluated each cycle
    assign stall = port_hit || lu_hit;

    always_comb begin
        st_d = st_q;
        if (stall) begin
            st_d.sel_a = SRC_RF;
            st_d.sel_b = SRC_RF;
        end else begin
            st_d.sel_a = opnd_src_e'(pick[0]);
            st_d.sel_b = opnd_src_e'(pick[1]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sel_a <= SRC_RF;
            st_q.sel_b <= SRC_RF;
        end else begin
            st_q <= st_d;
        end
    end

    assign front_stall = stall;
    assign ex_bubble   = stall;
    assign fwd_sel_a   = st_q.sel_a;
    assign fwd_sel_b   = st_q.sel_b;

endmodule

// File: rtl/hzd_interlock_chk.sv
module hzd_interlock_chk #(
    parameter int REG_AW = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              id_valid,
    input logic [1:0]        id_cls,
    input logic [REG_AW-1:0] id_src_a,
    input logic [REG_AW-1:0] id_src_b,
    input logic              ex_valid,
    input logic [1:0]        ex_cls,
    input logic [REG_AW-1:0] ex_dst,
    input logic              mem_valid,
    input logic [1:0]        mem_cls,
    input logic [REG_AW-1:0] mem_dst,
    input logic              wb_valid,
    input logic [1:0]        wb_cls,
    input logic              front_stall,
    input logic              ex_bubble,
    input logic [1:0]        fwd_sel_a,
    input logic [1:0]        fwd_sel_b
);
    p_struct_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid && id_cls == 2'b00 && wb_valid && (wb_cls == 2'b00 || wb_cls == 2'b01))
        |-> front_stall);

    p_loaduse_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid && ex_valid && ex_cls == 2'b01 && ex_dst != '0 && id_src_a == ex_dst)
        |-> (front_stall && ex_bubble));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !id_valid |-> (!front_stall && !ex_bubble));

    p_bubble_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ex_bubble |=> (fwd_sel_a == 2'b00 && fwd_sel_b == 2'b00));

    p_newest_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!front_stall && id_valid && id_src_a != '0 && ex_valid && ex_cls == 2'b00
         && ex_dst == id_src_a) |=> (fwd_sel_a == 2'b01));

    p_zero_reg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (id_src_a == '0) |=> (fwd_sel_a == 2'b00));

    p_single_read_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (id_cls != 2'b00) |=> (fwd_sel_b == 2'b00));

    p_sel_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_sel_a != 2'b11) && (fwd_sel_b != 2'b11));

    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_sel_r1: assert (fwd_sel_a == 2'b00 || $isunknown(fwd_sel_a));
        end
    end
endmodule

bind hzd_interlock hzd_interlock_chk #(.REG_AW(REG_AW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .id_valid    (id_valid),
    .id_cls      (id_cls),
    .id_src_a    (id_src_a),
    .id_src_b    (id_src_b),
    .ex_valid    (ex_valid),
    .ex_cls      (ex_cls),
    .ex_dst      (ex_dst),
    .mem_valid   (mem_valid),
    .mem_cls     (mem_cls),
    .mem_dst     (mem_dst),
    .wb_valid    (wb_valid),
    .wb_cls      (wb_cls),
    .front_stall (front_stall),
    .ex_bubble   (ex_bubble),
    .fwd_sel_a   (fwd_sel_a),
    .fwd_sel_b   (fwd_sel_b)
);

// File: tb/hzd_interlock_tb.sv
`timescale 1ns/1ps
module hzd_interlock_tb_top;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          id_valid = 0, ex_valid = 0, mem_valid = 0, wb_valid = 0;
    logic [1:0]    id_cls = 0, ex_cls = 0, mem_cls = 0, wb_cls = 0;
    logic [AW-1:0] id_src_a = 0, id_src_b = 0, ex_dst = 0, mem_dst = 0;
    logic          front_stall, ex_bubble;
    logic [1:0]    fwd_sel_a, fwd_sel_b;

    int    errors = 0;
    int    checks = 0;
    int    exp_a = 0, exp_b = 0;
    string tag_a = "R1", tag_b = "R1";
    bit    done = 0;

    always #2 clk = ~clk;

    hzd_interlock #(.REG_AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .id_valid(id_valid), .id_cls(id_cls), .id_src_a(id_src_a), .id_src_b(id_src_b),
        .ex_valid(ex_valid), .ex_cls(ex_cls), .ex_dst(ex_dst),
        .mem_valid(mem_valid), .mem_cls(mem_cls), .mem_dst(mem_dst),
        .wb_valid(wb_valid), .wb_cls(wb_cls),
        .front_stall(front_stall), .ex_bubble(ex_bubble),
        .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b)
    );

    function automatic bit writer(int c);
        return c == 0 || c == 1;
    endfunction

    function automatic bit m_struct();
        return id_valid && id_cls == 0 && wb_valid && writer(int'(wb_cls));
    endfunction

    function automatic bit m_loaduse();
        if (!(id_valid && ex_valid && ex_cls == 1 && ex_dst != 0)) return 0;
        return (id_src_a == ex_dst) || (id_cls == 0 && id_src_b == ex_dst);
    endfunction

    function automatic int m_pick(bit used, int s);
        if (!used || s == 0) return 0;
        if (ex_valid && ex_cls == 0 && int'(ex_dst) == s) return 1;
        if (mem_valid && writer(int'(mem_cls)) && int'(mem_dst) == s) return 2;
        return 0;
    endfunction

    task automatic check(string tag, string what, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, expv, $time);
        end
    endtask

    // Drive one cycle of descriptors at the falling edge, check outputs.
    task automatic step(bit iv, int ic, int sa, int sb, bit ev, int ec, int ed,
                        bit mv, int mc, int md, bit wv, int wc);
        bit st, lu, stl;
        string stag;
        @(negedge clk);
        // selects registered at the last rising edge
        check(tag_a, "fwd_sel_a", int'(fwd_sel_a), exp_a);
        check(tag_b, "fwd_sel_b", int'(fwd_sel_b), exp_b);
        id_valid = iv; id_cls = ic[1:0]; id_src_a = sa[AW-1:0]; id_src_b = sb[AW-1:0];
        ex_valid = ev; ex_cls = ec[1:0]; ex_dst = ed[AW-1:0];
        mem_valid = mv; mem_cls = mc[1:0]; mem_dst = md[AW-1:0];
        wb_valid = wv; wb_cls = wc[1:0];
        #1;
        st  = m_struct();
        lu  = m_loaduse();
        stl = st || lu;
        if (st && lu)  stag = "R10";
        else if (st)   stag = "R3";
        else if (lu)   stag = "R4";
        else if (!iv)  stag = "R8";
        else           stag = "R2";
        check(stag, "front_stall", int'(front_stall), int'(stl));
        check("R2", "ex_bubble", int'(ex_bubble), int'(stl));
        if (stl) begin
            exp_a = 0; exp_b = 0; tag_a = "R10"; tag_b = "R10";
        end else begin
            exp_a = m_pick(iv, sa);
            exp_b = m_pick(iv && ic == 0, sb);
            tag_a = exp_a == 1 ? "R5" : exp_a == 2 ? "R6" : sa == 0 ? "R7" : "R8";
            tag_b = ic != 0 ? "R9" : exp_b == 1 ? "R5" : exp_b == 2 ? "R6" :
                    sb == 0 ? "R7" : "R8";
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: selects are clear during reset
        check("R1", "fwd_sel_a in reset", int'(fwd_sel_a), 0);
        check("R1", "fwd_sel_b in reset", int'(fwd_sel_b), 0);
        rst_n = 1'b1;
        exp_a = 0; exp_b = 0;
        // R3: dual read vs writing WB, then vs a store in WB (no conflict)
        step(1,0,3,4, 0,0,0, 0,0,0, 1,0);
        step(1,0,3,4, 0,0,0, 0,0,0, 1,2);
        step(1,0,3,4, 0,0,0, 0,0,0, 1,1);
        // R4: load in EX feeds ID, then resumes with load in MEM (R10, R6)
        step(1,0,7,2, 1,1,7, 0,0,0, 0,0);
        step(1,0,7,2, 0,0,0, 1,1,7, 0,0);
        step(0,0,0,0, 0,0,0, 0,0,0, 0,0);
        // R5: both EX and MEM match -> newest
        step(1,0,5,5, 1,0,5, 1,0,5, 0,0);
        step(0,0,0,0, 0,0,0, 0,0,0, 0,0);
        // R7: register zero
        step(1,0,0,0, 1,0,0, 1,1,0, 0,0);
        step(1,0,0,0, 1,1,0, 0,0,0, 0,0);
        // R8: invalid producers
        step(1,0,6,6, 0,0,6, 0,1,6, 0,0);
        step(0,0,6,6, 1,1,6, 1,0,6, 1,0);
        // R9: store in ID with B matching; store/branch in EX never bypass
        step(1,2,1,9, 1,0,9, 1,0,9, 0,0);
        step(1,1,2,8, 1,1,8, 0,0,0, 1,0);
        step(1,0,4,4, 1,2,4, 1,3,4, 0,0);
        // R10: structural and load-use together
        step(1,0,3,8, 1,1,3, 0,0,0, 1,0);
        step(1,0,3,8, 0,0,0, 1,1,3, 0,0);
        step(0,0,0,0, 0,0,0, 0,0,0, 0,0);
        // mixed random descriptors over a small register range
        for (int i = 0; i < 4000; i++) begin
            step($urandom_range(1,0), $urandom_range(3,0), $urandom_range(3,0),
                 $urandom_range(3,0), $urandom_range(1,0), $urandom_range(3,0),
                 $urandom_range(3,0), $urandom_range(1,0), $urandom_range(3,0),
                 $urandom_range(3,0), $urandom_range(1,0), $urandom_range(3,0));
        end
        step(0,0,0,0, 0,0,0, 0,0,0, 0,0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule